// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address by reading a two-level page table held in memory. A start strobe captures three inputs: the virtual address, the access kind, and the physical base of the top-level table. The walker then reads the top-level (directory) entry. If that entry is present, it reads the leaf entry from the table the directory entry names. It ends with either a physical address or a fault and a cause code, and it holds that result until the next walk starts.

Memory access uses a minimal port. The walker raises `mem_req` for exactly one cycle with a word address. Memory answers later with `mem_rvalid` and `mem_rdata`. Every table entry is one 32-bit word with these fields:

- bit 0: present.
- bit 1: read allowed.
- bit 2: write allowed.
- bit 3: execute allowed.
- bit 4: referenced.
- bit 5: modified.
- bits 31:12: frame number.

The walker never writes to memory.

The controller has five states. IDLE waits for a start. DIR_REQ issues the directory read and always moves on to DIR_WAIT. DIR_WAIT waits for the response; it moves to PAGE_REQ if the entry is present, and otherwise returns to IDLE with a directory fault. PAGE_REQ issues the leaf read and always moves on to PAGE_WAIT. PAGE_WAIT waits for the response and returns to IDLE with either a translation or a fault.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `done`, `mem_req`, `page_fault` and `prot_fault` are 0, and `paddr` and `fault_cause` are 0.
- R2: The virtual address is split into three fields: bits 31:22 are the directory index, bits 21:12 are the leaf index, and bits 11:0 are the page offset. The first read goes to `root_base + dir_index*4`. For example, 0x00403004 uses directory index 1, leaf index 3 and offset 4.
- R3: The second read goes to `{dir_entry[31:12], 12'h000} + leaf_index*4`. It is issued only when bit 0 of the directory entry is 1, so a walk that completes without a directory fault makes exactly two reads.
- R4: On success, `paddr = {leaf_entry[31:12], vaddr[11:0]}`, `fault_cause` is 0 and both fault flags are 0. Entry bits 4 and 5 have no effect on the result.
- R5: If bit 0 of the directory entry is 0, the walk ends after that single read with `fault_cause = 2'b01` and `page_fault = 1`.
- R6: If bit 0 of the leaf entry is 0, the walk ends with `fault_cause = 2'b10` and `page_fault = 1`.
- R7: The access kind is encoded as 0 = read, 1 = write, 2 = execute, 3 = reserved. Kind 0 needs leaf bit 1, kind 1 needs leaf bit 2 and kind 2 needs leaf bit 3; kind 3 is never allowed. A present leaf without the needed bit ends the walk with `prot_fault = 1` and `fault_cause = 2'b11`. The permission bits of the directory entry are ignored.
- R8: Each memory request lasts exactly one cycle. A response is taken only while the walker is waiting for one.
- R9: A start that arrives while a walk is in progress is ignored, and the result belongs to the walk that was accepted.
- R10: `done`, `paddr`, `fault_cause` and both fault flags hold their values until the next accepted start, which clears `done`. No request is issued while `done` is 1.
- R11: On any fault, `paddr` is 0, and `page_fault` and `prot_fault` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a walk when the walker is idle |
| vaddr | input | 32 | Virtual address to translate |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| root_base | input | 32 | Physical address of the top-level table |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Address of the requested entry |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response entry |
| done | output | 1 | Walk finished; held until the next start |
| paddr | output | 32 | Translated physical address |
| page_fault | output | 1 | An entry was not present |
| prot_fault | output | 1 | Access kind not permitted by the leaf |
| fault_cause | output | 2 | 0 none, 1 directory absent, 2 leaf absent, 3 permission |

## Verification
The bench targets a directory entry that has its read, write and execute bits set but bit 0 clear. A walker that skipped the present test, or that issued the second read anyway, would return an address or show an extra request instead of cause 1.

It sends each access kind, including the reserved one, to pages with a single permission bit. A wrong bit mapping would then grant or deny the wrong kind. It also uses a directory entry with no permission bits at all, which would catch a walker that checked rights at the first level.

Three further cases cover corners of the datapath and control:

- An all-ones leaf frame with the highest offset exposes a truncated concatenation.
- Response latencies of one to three cycles expose a walker that reads data in the request cycle.
- A start that arrives mid-walk would, if honoured, corrupt the latched address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FC_OK          = 2'd0,
        FC_DIR_ABSENT  = 2'd1,
        FC_PAGE_ABSENT = 2'd2,
        FC_DENIED      = 2'd3
    } fault_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_PAGE_REQ,
        ST_PAGE_WAIT
    } walk_st_e;

    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_RD_BIT    = 1;
    localparam int PTE_WR_BIT    = 2;
    localparam int PTE_EX_BIT    = 3;
    localparam int ENTRY_BYTES_LOG2 = 2;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int AW    = 32,
    parameter int IDX_W = 10
) (
    input  logic [AW-1:0]    tbl_base,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    ent_addr
);
    localparam int SHIFT = ptw_pkg::ENTRY_BYTES_LOG2;
    localparam int SPAN  = IDX_W + SHIFT;

    logic [SPAN-1:0] byte_off;

    assign byte_off = {idx, {SHIFT{1'b0}}};
    assign ent_addr = tbl_base + AW'(byte_off);
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
#(
    parameter int PTE_W = 32
) (
    input  logic [PTE_W-1:0] pte,
    input  acc_kind_e        kind,
    output logic             present,
    output logic             allowed
);
    assign present = pte[PTE_VALID_BIT];

    always_comb begin
        unique case (kind)
            ACC_LOAD:  allowed = pte[PTE_RD_BIT];
            ACC_STORE: allowed = pte[PTE_WR_BIT];
            ACC_FETCH: allowed = pte[PTE_EX_BIT];
            default:   allowed = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter  int TOP_IDX_W  = 10,
    parameter  int LEAF_IDX_W = 10,
    parameter  int OFF_W      = 12,
    localparam int VA_W       = TOP_IDX_W + LEAF_IDX_W + OFF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VA_W-1:0] vaddr,
    input  logic [1:0]      acc_kind,
    input  logic [VA_W-1:0] root_base,
    output logic            mem_req,
    output logic [VA_W-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [VA_W-1:0] mem_rdata,
    output logic            done,
    output logic [VA_W-1:0] paddr,
    output logic            page_fault,
    output logic            prot_fault,
    output logic [1:0]      fault_cause
);
    localparam int FRAME_W = VA_W - OFF_W;
    localparam int TOP_LSB = LEAF_IDX_W + OFF_W;

    walk_st_e          state_q, state_d;
    logic [VA_W-1:0]   va_q;
    logic [VA_W-1:0]   base_q;
    acc_kind_e         kind_q;
    logic [FRAME_W-1:0] leaf_tbl_q;

    logic [VA_W-1:0]   dir_addr, leaf_addr;
    logic              ent_present, ent_allowed;

    ptw_entry_addr #(.AW(VA_W), .IDX_W(TOP_IDX_W)) u_dir_addr (
        .tbl_base (base_q),
        .idx      (va_q[VA_W-1 -: TOP_IDX_W]),
        .ent_addr (dir_addr)
    );

    ptw_entry_addr #(.AW(VA_W), .IDX_W(LEAF_IDX_W)) u_leaf_addr (
        .tbl_base ({leaf_tbl_q, {OFF_W{1'b0}}}),
        .idx      (va_q[TOP_LSB-1 -: LEAF_IDX_W]),
        .ent_addr (leaf_addr)
    );

    ptw_perm_check #(.PTE_W(VA_W)) u_perm (
        .pte     (mem_rdata),
        .kind    (kind_q),
        .present (ent_present),
        .allowed (ent_allowed)
    );

    assign mem_req  = (state_q == ST_DIR_REQ) || (state_q == ST_PAGE_REQ);
    assign mem_addr = (state_q == ST_PAGE_REQ) ? leaf_addr : dir_addr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_DIR_REQ;
            ST_DIR_REQ:   state_d = ST_DIR_WAIT;
            ST_DIR_WAIT:  if (mem_rvalid) state_d = ent_present ? ST_PAGE_REQ : ST_IDLE;
            ST_PAGE_REQ:  state_d = ST_PAGE_WAIT;
            ST_PAGE_WAIT: if (mem_rvalid) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register and walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            va_q       <= '0;
            base_q     <= '0;
            kind_q     <= ACC_LOAD;
            leaf_tbl_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                va_q   <= vaddr;
                base_q <= root_base;
                kind_q <= acc_kind_e'(acc_kind);
            end
            if (state_q == ST_DIR_WAIT && mem_rvalid)
                leaf_tbl_q <= mem_rdata[VA_W-1 -: FRAME_W];
        end
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            paddr       <= '0;
            page_fault  <= 1'b0;
            prot_fault  <= 1'b0;
            fault_cause <= FC_OK;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    done        <= 1'b0;
                    paddr       <= '0;
                    page_fault  <= 1'b0;
                    prot_fault  <= 1'b0;
                    fault_cause <= FC_OK;
                end
                ST_DIR_WAIT: if (mem_rvalid && !ent_present) begin
                    done        <= 1'b1;
                    page_fault  <= 1'b1;
                    fault_cause <= FC_DIR_ABSENT;
                end
                ST_PAGE_WAIT: if (mem_rvalid) begin
                    done <= 1'b1;
                    if (!ent_present) begin
                        page_fault  <= 1'b1;
                        fault_cause <= FC_PAGE_ABSENT;
                    end else if (!ent_allowed) begin
                        prot_fault  <= 1'b1;
                        fault_cause <= FC_DENIED;
                    end else begin
                        paddr <= {mem_rdata[VA_W-1 -: FRAME_W], va_q[OFF_W-1:0]};
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            mem_req,
    input logic            done,
    input logic [VA_W-1:0] paddr,
    input logic            page_fault,
    input logic            prot_fault,
    input logic [1:0]      fault_cause
);
    logic       done_q;
    logic [2:0] req_cnt;
    logic       done_rise;

    assign done_rise = done && !done_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            req_cnt <= '0;
        end else begin
            done_q <= done;
            if (done_rise)    req_cnt <= '0;
            else if (mem_req) req_cnt <= req_cnt + 3'd1;
        end
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R8
    AST_DIR_FAULT_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (done_rise && fault_cause == 2'b01) |-> req_cnt == 3'd1); // R5
    AST_FULL_WALK_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_rise && fault_cause != 2'b01) |-> req_cnt == 3'd2); // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(paddr) && $stable(fault_cause))); // R10
    AST_NO_REQ_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R10
    AST_FAULT_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(page_fault && prot_fault)); // R11
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (page_fault || prot_fault) |-> paddr == '0); // R11
endmodule

bind ptw_walker ptw_walker_chk #(.VA_W(VA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mem_req     (mem_req),
    .done        (done),
    .paddr       (paddr),
    .page_fault  (page_fault),
    .prot_fault  (prot_fault),
    .fault_cause (fault_cause)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;

    typedef struct {
        logic [31:0] pa;
        logic [1:0]  fc;
        int          nreq;
        logic [31:0] a1;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] vaddr = '0;
    logic [1:0]  acc_kind = '0;
    logic [31:0] root_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] paddr;
    logic        page_fault, prot_fault;
    logic [1:0]  fault_cause;

    logic [31:0] mem [logic [31:0]];
    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    int          lat = 1;
    int          req_cnt = 0;
    logic [31:0] first_addr = '0;
    logic        done_prev = 1'b0;

    always #4 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
        .acc_kind(acc_kind), .root_base(root_base),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .paddr(paddr), .page_fault(page_fault),
        .prot_fault(prot_fault), .fault_cause(fault_cause)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] va, input logic [1:0] k,
                                   input logic [31:0] base, input string tag);
        exp_t        e;
        logic [31:0] d, l;
        bit          ok;
        e.tag = tag; e.pa = '0; e.fc = 2'd0;
        e.a1  = base + {20'h0, va[31:22], 2'b00};
        d = rd(e.a1);
        if (!d[0]) begin
            e.fc = 2'd1; e.nreq = 1;
            return e;
        end
        e.nreq = 2;
        l = rd({d[31:12], 12'h000} + {20'h0, va[21:12], 2'b00});
        if (!l[0]) begin
            e.fc = 2'd2;
            return e;
        end
        case (k)
            2'd0: ok = l[1];
            2'd1: ok = l[2];
            2'd2: ok = l[3];
            default: ok = 1'b0;
        endcase
        if (!ok) e.fc = 2'd3;
        else     e.pa = {l[31:12], va[11:0]};
        return e;
    endfunction

    // Memory responder
    initial begin
        logic [31:0] a;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (mem_req) begin
                if (req_cnt == 0) first_addr = mem_addr;
                req_cnt++;
                a = mem_addr;
                repeat (lat) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = rd(a);
            end
        end
    end

    // Scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && done && !done_prev) begin
                if (sb.size() == 0) begin
                    chk(0, "R9", "unexpected completion", 32'h1, 32'h0);
                end else begin
                    e = sb.pop_front();
                    chk(paddr == e.pa, e.tag, "paddr", paddr, e.pa);
                    chk(fault_cause == e.fc, e.tag, "fault_cause", 32'(fault_cause), 32'(e.fc));
                    chk(page_fault == (e.fc == 2'd1 || e.fc == 2'd2), e.tag, "page_fault",
                        32'(page_fault), 32'(e.fc == 2'd1 || e.fc == 2'd2));
                    chk(prot_fault == (e.fc == 2'd3), e.tag, "prot_fault",
                        32'(prot_fault), 32'(e.fc == 2'd3));
                    chk(req_cnt == e.nreq, (e.nreq == 1) ? "R5" : "R3", "read count",
                        32'(req_cnt), 32'(e.nreq));
                    chk(first_addr == e.a1, "R2", "directory read address", first_addr, e.a1);
                end
            end
            done_prev = done;
        end
    end

    task automatic walk(input logic [31:0] va, input logic [1:0] k,
                        input logic [31:0] base, input string tag, input bit poke);
        sb.push_back(model(va, k, base, tag));
        @(negedge clk);
        req_cnt   = 0;
        start     = 1'b1;
        vaddr     = va;
        acc_kind  = k;
        root_base = base;
        @(negedge clk);
        if (poke) begin
            vaddr    = 32'h0080_0000;
            acc_kind = 2'd3;
        end else begin
            start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        do @(negedge clk); while (!done);
        lat = (lat % 3) + 1;
    endtask

    initial begin
        logic [31:0] held;
        mem[32'h0001_0004] = 32'h0002_0001;   // directory entry, no rights bits
        mem[32'h0002_000C] = 32'h0ABC_D03F;   // rwe plus referenced/modified
        mem[32'h0002_0010] = 32'h0123_4003;   // read only
        mem[32'h0002_0014] = 32'h0555_5009;   // execute only
        mem[32'h0002_0018] = 32'h0777_700E;   // rwe but absent
        mem[32'h0001_0FFC] = 32'h0003_000E;   // directory rwe but absent
        mem[32'h0001_0000] = 32'h0004_0001;
        mem[32'h0004_0FFC] = 32'hFFFF_F007;
        mem[32'h0005_0004] = 32'h0004_0001;
        mem[32'h0004_000C] = 32'h0666_6003;

        repeat (3) @(negedge clk);
        chk(done == 1'b0 && mem_req == 1'b0, "R1", "reset done/req", {30'h0, done, mem_req}, 32'h0);
        chk(paddr == '0 && fault_cause == 2'd0 && !page_fault && !prot_fault, "R1", "reset result",
            paddr, 32'h0);
        rst_n = 1'b1;

        walk(32'h0040_3004, 2'd0, 32'h0001_0000, "R4", 0);
        chk(paddr == 32'h0ABC_D004, "R2", "split of 0x00403004", paddr, 32'h0ABC_D004);
        held = paddr;
        repeat (6) @(negedge clk);
        chk(done && paddr == held && fault_cause == 2'd0, "R10", "result held", paddr, held);
        walk(32'h0040_3ABC, 2'd1, 32'h0001_0000, "R4", 0);
        walk(32'h0040_3000, 2'd2, 32'h0001_0000, "R7", 0);
        walk(32'h0040_4010, 2'd0, 32'h0001_0000, "R7", 0);
        walk(32'h0040_4010, 2'd1, 32'h0001_0000, "R7", 0);
        walk(32'h0040_5008, 2'd0, 32'h0001_0000, "R7", 0);
        walk(32'h0040_5008, 2'd2, 32'h0001_0000, "R7", 0);
        walk(32'h0040_3004, 2'd3, 32'h0001_0000, "R7", 0);
        walk(32'h0040_6000, 2'd0, 32'h0001_0000, "R6", 0);
        walk(32'h0080_0000, 2'd0, 32'h0001_0000, "R5", 0);
        walk(32'hFFC0_0123, 2'd0, 32'h0001_0000, "R5", 0);
        chk(paddr == '0 && page_fault && !prot_fault, "R11", "fault result", paddr, 32'h0);
        walk(32'h003F_FFFF, 2'd0, 32'h0001_0000, "R4", 0);
        walk(32'h0040_3004, 2'd0, 32'h0005_0000, "R2", 0);
        walk(32'h0040_3004, 2'd1, 32'h0001_0000, "R9", 1);
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R9", "pending results", 32'(sb.size()), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule